// File: doc/BRIEF.md
# ECC Memory Controller Register Bank

This block holds the control and status registers of an ECC memory controller. A simple single-cycle bus port reaches nine 32-bit registers in a main window: enable, delay, fault status, video configuration, two fault address words, a diagnostic word and two event counters. Some chip variants also have a small byte-wide diagnostic window. The encode and decode datapath, DRAM timing, refresh and arbitration live elsewhere. The delay and configuration words are only stored here and driven out as plain configuration pins.

An error-report strobe from the ECC datapath loads the fault status word and both fault address words. It also tracks whether a second error arrived before software cleared the first. It raises an interrupt for uncorrectable errors, and for correctable ones when software has allowed that. Software acknowledges the interrupt by writing the fault status register.

The `VARIANT` parameter (0, 1 or 2) selects the per-variant behaviour: which enable bits software can write, whether the variant number appears in the top nibble of the enable register, which enable bits survive a soft reset, and whether the diagnostic window exists. There are two resets. `por_n` is an asynchronous power-on reset that clears everything. `rst_n` is a synchronous soft reset that restores defaults but keeps some enable bits.

Top module: `ecc_ctl_regs`

## Requirements
- R1: A main-window register is selected by `bus_addr[5:2]`: enable 0, delay 1, fault status 2, video 3, fault address 0 at 4, fault address 1 at 5, diagnostic 6, event count 0 at 7, event count 1 at 8. A write to event count 1 changes only event count 1. Indexes 9 to 15 read as zero, and writes to them change nothing.
- R2: An enable write stores `bus_wdata & 0x00000103` on variant 0. On variants 1 and 2 it stores `(bus_wdata & 0x00000BFF) | (VARIANT << 28)`. After power-on the enable register reads `VARIANT << 28`, and bits 27:24 always read zero.
- R3: A delay write stores `bus_wdata & 0x7FFFFFFF`, so bit 31 of the delay register always reads zero.
- R4: A fault-status write stores `bus_wdata` and drops `irq` on the next edge, unless an interrupt-raising error report arrives in the same cycle.
- R5: Both fault address registers ignore bus writes. Only an error report changes them.
- R6: After power-on or soft reset: delay is 0x00000020, fault address 0 is 0x07C00000, and fault status, video, fault address 1, diagnostic, both event counters and `irq` are 0.
- R7: A soft reset ANDs the enable register with 0x00000100 on variant 0, and with 0xFF000BFC on variants 1 and 2.
- R8: The main window acts only on accesses with `bus_win`=0 and `bus_size`=2 (word). For any other size, writes are ignored and reads return zero.
- R9: On variant 0 only, `bus_win`=1 with `bus_size`=0 (byte) reaches four bytes indexed by `bus_addr[1:0]`. Read data comes back on `bus_rdata[7:0]` with the upper bits zero. On other variants these accesses read zero and store nothing. The bytes are cleared only by power-on.
- R10: An error report loads fault status with correctable at bit 0, timeout at bit 2, uncorrectable at bit 3, double-word index `err_dw` at bits 7:4 and syndrome `err_synd` at bits 15:8. It loads `err_addr0` and `err_addr1` into the two fault address registers.
- R11: The multiple-errors bit 16 is set by a report when the old status already had bit 0, 2, 3 or 16 set. Otherwise it is cleared.
- R12: An error report raises `irq` on the next edge when `err_ue` is set, or when `err_ce` is set and enable bit 1 is set.
- R13: When an error report and a fault-status write fall in the same cycle, the report's captured value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous soft reset, active low |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_win | input | 1 | Window select: 0 main, 1 diagnostic |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_addr | input | 6 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when `bus_rd` is low |
| err_valid | input | 1 | Error report strobe |
| err_ce | input | 1 | Correctable error flag |
| err_to | input | 1 | Write timeout flag |
| err_ue | input | 1 | Uncorrectable error flag |
| err_dw | input | 4 | Double-word index in block |
| err_synd | input | 8 | Syndrome |
| err_addr0 | input | 32 | Fault address word 0 |
| err_addr1 | input | 32 | Fault address word 1 |
| irq | output | 1 | Interrupt request |
| cfg_enable | output | 32 | Enable register contents |
| cfg_delay | output | 32 | Delay register contents |
| cfg_video | output | 32 | Video configuration contents |
| cfg_diag | output | 32 | Diagnostic register contents |

## Verification
The hardest case to reach from the ports is an error report landing in the same cycle as a software write to fault status. That cycle decides both the status value and whether the interrupt stays up. A second hard case is a report arriving while earlier flags are still set, which must mark multiple errors.

Directed steps force both cases with known flags. The random phase issues reports in about one cycle in five and aims about a third of its writes at the status offset, so collisions and back-to-back reports recur. Both a variant-0 and a variant-1 instance see the same stimulus, so the masks and retention differ side by side.

// File: rtl/ecc_regs_pkg.sv
`timescale 1ns/1ps
package ecc_regs_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 6;
  localparam int IDX_W   = ADDR_W - 2;
  localparam int DIAG_N  = 4;
  localparam int DIAG_IW = $clog2(DIAG_N);

  localparam logic [IDX_W-1:0] IDX_EN   = 4'd0;
  localparam logic [IDX_W-1:0] IDX_DLY  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_STAT = 4'd2;
  localparam logic [IDX_W-1:0] IDX_VID  = 4'd3;
  localparam logic [IDX_W-1:0] IDX_FA0  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_FA1  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_DIAG = 4'd6;
  localparam logic [IDX_W-1:0] IDX_EC0  = 4'd7;
  localparam logic [IDX_W-1:0] IDX_EC1  = 4'd8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [REG_W-1:0] DLY_MASK = 32'h7FFF_FFFF;
  localparam logic [REG_W-1:0] DLY_RST  = 32'h0000_0020;
  localparam logic [REG_W-1:0] FA0_RST  = 32'h07C0_0000;

  // status bit positions
  localparam int ST_CE = 0;
  localparam int ST_TO = 2;
  localparam int ST_UE = 3;
  localparam int ST_DW = 4;
  localparam int ST_SY = 8;
  localparam int ST_ME = 16;

  function automatic logic [REG_W-1:0] en_wmask(input int variant);
    return (variant == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
  endfunction

  function automatic logic [REG_W-1:0] en_keep(input int variant);
    return (variant == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
  endfunction

  function automatic logic [REG_W-1:0] en_ident(input int variant);
    return {variant[3:0], 28'h0};
  endfunction
endpackage

// File: rtl/ecc_err_capture.sv
`timescale 1ns/1ps
module ecc_err_capture
  import ecc_regs_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             err_valid,
  input  logic             err_ce,
  input  logic             err_to,
  input  logic             err_ue,
  input  logic [3:0]       err_dw,
  input  logic [7:0]       err_synd,
  input  logic [REG_W-1:0] err_addr0,
  input  logic [REG_W-1:0] err_addr1,
  input  logic             ce_irq_en,
  input  logic             st_wr,
  input  logic [REG_W-1:0] st_wdata,
  output logic [REG_W-1:0] status,
  output logic [REG_W-1:0] fault_a0,
  output logic [REG_W-1:0] fault_a1,
  output logic             irq
);
  logic             prior_err;
  logic             raise;
  logic [REG_W-1:0] cap_word;

  assign prior_err = status[ST_CE] | status[ST_TO] | status[ST_UE] | status[ST_ME];
  assign raise     = err_valid & (err_ue | (err_ce & ce_irq_en));

  always_comb begin
    cap_word              = '0;
    cap_word[ST_CE]       = err_ce;
    cap_word[ST_TO]       = err_to;
    cap_word[ST_UE]       = err_ue;
    cap_word[ST_DW +: 4]  = err_dw;
    cap_word[ST_SY +: 8]  = err_synd;
    cap_word[ST_ME]       = prior_err;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      status   <= '0;
      fault_a0 <= FA0_RST;
      fault_a1 <= '0;
      irq      <= 1'b0;
    end else if (!rst_n) begin
      status   <= '0;
      fault_a0 <= FA0_RST;
      fault_a1 <= '0;
      irq      <= 1'b0;
    end else begin
      if (err_valid) begin
        status   <= cap_word;
        fault_a0 <= err_addr0;
        fault_a1 <= err_addr1;
      end else if (st_wr) begin
        status <= st_wdata;
      end
      if (raise)      irq <= 1'b1;
      else if (st_wr) irq <= 1'b0;
    end
  end

  assert_irq_raise_R12: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    err_valid && err_ue |=> irq);
  assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    st_wr && !err_valid |=> !irq);
  assert_fa_readonly_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !err_valid |=> $stable(fault_a0) && $stable(fault_a1));
  assert_multi_err_R11: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    err_valid && (status[ST_CE] || status[ST_UE] || status[ST_TO]) |=> status[ST_ME]);
  assert_report_wins_R13: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    err_valid && st_wr |=> status[3:0] == {$past(err_ue), $past(err_to), 1'b0, $past(err_ce)});
endmodule

// File: rtl/ecc_diag_window.sv
`timescale 1ns/1ps
module ecc_diag_window
  import ecc_regs_pkg::*;
#(
  parameter bit PRESENT = 1'b1
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               wr,
  input  logic [DIAG_IW-1:0] idx,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata
);
  generate
    if (PRESENT) begin : g_on
      logic [7:0] mem [DIAG_N];
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
          for (int b = 0; b < DIAG_N; b++) mem[b] <= '0;
        end else if (wr) begin
          for (int b = 0; b < DIAG_N; b++)
            if (idx == DIAG_IW'(b)) mem[b] <= wdata;
        end
      end
      assign rdata = mem[idx];

      assert_diag_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
        !wr |=> $stable(mem[0]) && $stable(mem[DIAG_N-1]));
    end else begin : g_off
      logic unused_diag;
      assign unused_diag = ^{clk, por_n, wr, idx, wdata};
      assign rdata = '0;
    end
  endgenerate
endmodule

// File: rtl/ecc_ctl_regs.sv
`timescale 1ns/1ps
module ecc_ctl_regs
  import ecc_regs_pkg::*;
#(
  parameter int VARIANT = 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_win,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              err_valid,
  input  logic              err_ce,
  input  logic              err_to,
  input  logic              err_ue,
  input  logic [3:0]        err_dw,
  input  logic [7:0]        err_synd,
  input  logic [REG_W-1:0]  err_addr0,
  input  logic [REG_W-1:0]  err_addr1,
  output logic              irq,
  output logic [REG_W-1:0]  cfg_enable,
  output logic [REG_W-1:0]  cfg_delay,
  output logic [REG_W-1:0]  cfg_video,
  output logic [REG_W-1:0]  cfg_diag
);
  localparam bit               HAS_DIAG = (VARIANT == 0);
  localparam logic [REG_W-1:0] WMASK    = en_wmask(VARIANT);
  localparam logic [REG_W-1:0] KEEP     = en_keep(VARIANT);
  localparam logic [REG_W-1:0] IDENT    = en_ident(VARIANT);
  localparam int               NPLAIN   = 4;
  localparam logic [IDX_W-1:0] PLAIN_IDX [NPLAIN] = '{IDX_VID, IDX_DIAG, IDX_EC0, IDX_EC1};

  logic             main_acc, diag_acc, wr_main;
  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] en_q, dly_q;
  logic [REG_W-1:0] plain_q [NPLAIN];
  logic [REG_W-1:0] status, fault_a0, fault_a1;
  logic [7:0]       diag_rdata;

  assign main_acc = !bus_win && (bus_size == SZ_WORD);
  assign diag_acc = bus_win && (bus_size == SZ_BYTE);
  assign idx      = bus_addr[ADDR_W-1:2];
  assign wr_main  = bus_wr && main_acc;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                        en_q <= IDENT;
    else if (!rst_n)                   en_q <= en_q & KEEP;
    else if (wr_main && idx == IDX_EN) en_q <= IDENT | (bus_wdata & WMASK);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                         dly_q <= DLY_RST;
    else if (!rst_n)                    dly_q <= DLY_RST;
    else if (wr_main && idx == IDX_DLY) dly_q <= bus_wdata & DLY_MASK;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n || !rst_n) begin
      for (int g = 0; g < NPLAIN; g++) plain_q[g] <= '0;
    end else if (wr_main) begin
      for (int g = 0; g < NPLAIN; g++)
        if (idx == PLAIN_IDX[g]) plain_q[g] <= bus_wdata;
    end
  end

  ecc_err_capture u_cap (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .err_valid (err_valid),
    .err_ce    (err_ce),
    .err_to    (err_to),
    .err_ue    (err_ue),
    .err_dw    (err_dw),
    .err_synd  (err_synd),
    .err_addr0 (err_addr0),
    .err_addr1 (err_addr1),
    .ce_irq_en (en_q[1]),
    .st_wr     (wr_main && idx == IDX_STAT),
    .st_wdata  (bus_wdata),
    .status    (status),
    .fault_a0  (fault_a0),
    .fault_a1  (fault_a1),
    .irq       (irq)
  );

  ecc_diag_window #(.PRESENT(HAS_DIAG)) u_diag (
    .clk   (clk),
    .por_n (por_n),
    .wr    (bus_wr && diag_acc && rst_n),
    .idx   (bus_addr[DIAG_IW-1:0]),
    .wdata (bus_wdata[7:0]),
    .rdata (diag_rdata)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && main_acc) begin
      case (idx)
        IDX_EN:   bus_rdata = en_q;
        IDX_DLY:  bus_rdata = dly_q;
        IDX_STAT: bus_rdata = status;
        IDX_VID:  bus_rdata = plain_q[0];
        IDX_FA0:  bus_rdata = fault_a0;
        IDX_FA1:  bus_rdata = fault_a1;
        IDX_DIAG: bus_rdata = plain_q[1];
        IDX_EC0:  bus_rdata = plain_q[2];
        IDX_EC1:  bus_rdata = plain_q[3];
        default:  bus_rdata = '0;
      endcase
    end else if (bus_rd && diag_acc) begin
      bus_rdata = {24'h0, diag_rdata};
    end
  end

  assign cfg_enable = en_q;
  assign cfg_delay  = dly_q;
  assign cfg_video  = plain_q[0];
  assign cfg_diag   = plain_q[1];

  assert_dly_mask_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    wr_main && idx == IDX_DLY |=> cfg_delay == ($past(bus_wdata) & DLY_MASK));
  assert_en_keep_R7: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> cfg_enable == ($past(cfg_enable) & KEEP));
  assert_en_ident_R2: assert property (@(posedge clk) disable iff (!por_n)
    cfg_enable[31:24] == {4'(VARIANT), 4'h0});
  assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!por_n)
    bus_rd && main_acc && idx > IDX_EC1 |-> bus_rdata == '0);
endmodule

// File: tb/tb_ecc_ctl_regs.sv
`timescale 1ns/1ps
module tb_ecc_ctl_regs;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        por_n = 1'b0, rst_n = 1'b1;
  logic        b_wr = 0, b_rd = 0, b_win = 0;
  logic [1:0]  b_size = 2'd2;
  logic [5:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic        e_v = 0, e_ce = 0, e_to = 0, e_ue = 0;
  logic [3:0]  e_dw = '0;
  logic [7:0]  e_syn = '0;
  logic [31:0] e_a0 = '0, e_a1 = '0;

  logic [31:0] o_rd [2];
  logic        o_irq [2];
  logic [31:0] o_en [2], o_dly [2], o_vid [2], o_dg [2];

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // index 0: variant 1 (dut), index 1: variant 0 (dut_v0)
  ecc_ctl_regs #(.VARIANT(1)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_win(b_win), .bus_size(b_size), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_rdata(o_rd[0]), .err_valid(e_v), .err_ce(e_ce), .err_to(e_to), .err_ue(e_ue),
    .err_dw(e_dw), .err_synd(e_syn), .err_addr0(e_a0), .err_addr1(e_a1), .irq(o_irq[0]),
    .cfg_enable(o_en[0]), .cfg_delay(o_dly[0]), .cfg_video(o_vid[0]), .cfg_diag(o_dg[0]));

  ecc_ctl_regs #(.VARIANT(0)) dut_v0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_win(b_win), .bus_size(b_size), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_rdata(o_rd[1]), .err_valid(e_v), .err_ce(e_ce), .err_to(e_to), .err_ue(e_ue),
    .err_dw(e_dw), .err_synd(e_syn), .err_addr0(e_a0), .err_addr1(e_a1), .irq(o_irq[1]),
    .cfg_enable(o_en[1]), .cfg_delay(o_dly[1]), .cfg_video(o_vid[1]), .cfg_diag(o_dg[1]));

  // reference model
  logic [31:0] m_en [2], m_dly [2], m_st [2], m_vid [2], m_fa0 [2], m_fa1 [2];
  logic [31:0] m_dr [2], m_ec0 [2], m_ec1 [2];
  logic        m_irq [2];
  logic [7:0]  m_diag [4];

  function automatic int var_of(int k); return (k == 0) ? 1 : 0; endfunction
  function automatic logic [31:0] wmask(int v); return (v == 0) ? 32'h103 : 32'hBFF; endfunction
  function automatic logic [31:0] keepm(int v); return (v == 0) ? 32'h100 : 32'hFF000BFC; endfunction
  function automatic logic [31:0] ident(int v); return 32'(v) << 28; endfunction

  function automatic void m_soft(int k);
    m_dly[k] = 32'h20; m_st[k] = 0; m_vid[k] = 0; m_fa0[k] = 32'h07C00000; m_fa1[k] = 0;
    m_dr[k] = 0; m_ec0[k] = 0; m_ec1[k] = 0; m_irq[k] = 0;
  endfunction

  function automatic logic [31:0] exp_read(int k, logic win, logic [1:0] sz, logic [5:0] a);
    if (!win && sz == 2'd2) begin
      case (a[5:2])
        4'd0: return m_en[k];  4'd1: return m_dly[k]; 4'd2: return m_st[k];
        4'd3: return m_vid[k]; 4'd4: return m_fa0[k]; 4'd5: return m_fa1[k];
        4'd6: return m_dr[k];  4'd7: return m_ec0[k]; 4'd8: return m_ec1[k];
        default: return 32'h0;
      endcase
    end
    if (win && sz == 2'd0 && var_of(k) == 0) return {24'h0, m_diag[a[1:0]]};
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void m_step(int k, logic wr, logic win, logic [1:0] sz, logic [5:0] a,
                                 logic [31:0] wd, logic ev, logic ce, logic to, logic ue,
                                 logic [3:0] dw, logic [7:0] syn, logic [31:0] a0, logic [31:0] a1);
    int v = var_of(k);
    logic main_w = wr && !win && sz == 2'd2;
    logic stw = main_w && a[5:2] == 4'd2;
    logic raise = ev && (ue || (ce && m_en[k][1]));
    logic me = m_st[k][0] | m_st[k][2] | m_st[k][3] | m_st[k][16];
    if (ev) begin
      m_st[k] = {15'h0, me, syn, dw, ue, to, 1'b0, ce};
      m_fa0[k] = a0; m_fa1[k] = a1;
    end else if (stw) m_st[k] = wd;
    if (raise) m_irq[k] = 1'b1; else if (stw) m_irq[k] = 1'b0;
    if (main_w) begin
      case (a[5:2])
        4'd0: m_en[k]  = ident(v) | (wd & wmask(v));
        4'd1: m_dly[k] = wd & 32'h7FFFFFFF;
        4'd3: m_vid[k] = wd;
        4'd6: m_dr[k]  = wd;
        4'd7: m_ec0[k] = wd;
        4'd8: m_ec1[k] = wd;
        default: ;
      endcase
    end
    if (wr && win && sz == 2'd0 && v == 0) m_diag[a[1:0]] = wd[7:0];
  endfunction

  task automatic step(input logic wr, input logic rd, input logic win, input logic [1:0] sz,
                      input logic [5:0] a, input logic [31:0] wd, input logic ev,
                      input logic ce, input logic to, input logic ue, input logic [3:0] dw,
                      input logic [7:0] syn, input logic [31:0] a0, input logic [31:0] a1,
                      input string tag);
    @(negedge clk);
    b_wr = wr; b_rd = rd; b_win = win; b_size = sz; b_addr = a; b_wdata = wd;
    e_v = ev; e_ce = ce; e_to = to; e_ue = ue; e_dw = dw; e_syn = syn; e_a0 = a0; e_a1 = a1;
    #2;
    if (rd) for (int k = 0; k < 2; k++) chk(tag, o_rd[k], exp_read(k, win, sz, a));
    @(posedge clk);
    for (int k = 0; k < 2; k++) m_step(k, wr, win, sz, a, wd, ev, ce, to, ue, dw, syn, a0, a1);
    #2;
    for (int k = 0; k < 2; k++) begin
      chk("R12 irq", {31'h0, o_irq[k]}, {31'h0, m_irq[k]});
      chk("R2 enable", o_en[k], m_en[k]);
      chk("R3 delay", o_dly[k], m_dly[k]);
    end
    b_wr = 0; b_rd = 0; e_v = 0;
  endtask

  task automatic wr_w(input logic [3:0] i, input logic [31:0] d, input string tag);
    step(1, 0, 0, 2'd2, {i, 2'b00}, d, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rd_w(input logic [3:0] i, input string tag);
    step(0, 1, 0, 2'd2, {i, 2'b00}, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic report(input logic ce, input logic to, input logic ue, input string tag);
    step(0, 0, 0, 2'd2, 0, 0, 1, ce, to, ue, 4'h5, 8'hA7, 32'h1234_5678, 32'h9ABC_DEF0, tag);
  endtask
  task automatic soft_reset();
    @(negedge clk); rst_n = 0;
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin m_en[k] = m_en[k] & keepm(var_of(k)); m_soft(k); end
    #2;
    for (int k = 0; k < 2; k++) chk("R7 retain", o_en[k], m_en[k]);
    rst_n = 1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd97531));
    for (int k = 0; k < 2; k++) begin m_en[k] = ident(var_of(k)); m_soft(k); end
    for (int b = 0; b < 4; b++) m_diag[b] = 0;
    #35 por_n = 1;

    // R6: reset values of all main registers
    for (int i = 0; i < 9; i++) rd_w(4'(i), "R6 reset value");
    // R2: enable masks and identity
    wr_w(4'd0, 32'hFFFF_FFFF, "R2");
    rd_w(4'd0, "R2 enable mask");
    // R3: delay bit 31
    wr_w(4'd1, 32'hFFFF_FFFF, "R3");
    rd_w(4'd1, "R3 delay mask");
    // R5: fault address writes ignored
    wr_w(4'd4, 32'hDEAD_BEEF, "R5"); wr_w(4'd5, 32'hCAFE_F00D, "R5");
    rd_w(4'd4, "R5 fa0 readonly"); rd_w(4'd5, "R5 fa1 readonly");
    // R1: event count 1 independent, unmapped index
    wr_w(4'd8, 32'h0000_0ABC, "R1"); wr_w(4'd12, 32'h5555_5555, "R1");
    rd_w(4'd7, "R1 ec0"); rd_w(4'd8, "R1 ec1"); rd_w(4'd12, "R1 unmapped");
    // R8: half and byte writes to the main window ignored
    step(1, 0, 0, 2'd1, 6'd12, 32'h1111_1111, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 0, 0, 2'd0, 6'd24, 32'h2222_2222, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 1, 0, 2'd1, 6'd12, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 half read zero");
    rd_w(4'd3, "R8 video untouched"); rd_w(4'd6, "R8 diag untouched");
    // R9: diagnostic window
    for (int b = 0; b < 4; b++)
      step(1, 0, 1, 2'd0, 6'(b), 32'h40 + 32'(b * 17), 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    for (int b = 0; b < 4; b++)
      step(0, 1, 1, 2'd0, 6'(b), 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 diag byte");
    step(0, 1, 1, 2'd2, 6'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 word read zero");
    // R10, R12: correctable report with enable bit 1 set raises irq
    report(1, 0, 0, "R12");
    rd_w(4'd2, "R10 status"); rd_w(4'd4, "R10 fa0"); rd_w(4'd5, "R10 fa1");
    // R4: status write clears irq
    wr_w(4'd2, 32'h0, "R4 clear");
    // R11: back-to-back reports
    report(0, 0, 1, "R12 ue");
    report(0, 1, 0, "R11");
    rd_w(4'd2, "R11 multiple errors");
    wr_w(4'd2, 32'h0, "R4");
    report(0, 1, 0, "R11");
    rd_w(4'd2, "R11 clear history");
    // R13: report and status write collide
    step(1, 0, 0, 2'd2, 6'd8, 32'hFFFF_0000, 1, 0, 0, 1, 4'h3, 8'h5C, 32'h1, 32'h2, "R13");
    rd_w(4'd2, "R13 report wins");
    // R7: soft reset retention
    wr_w(4'd0, 32'hFFFF_FFFF, "R7");
    soft_reset();
    for (int i = 0; i < 9; i++) rd_w(4'(i), "R6 soft reset value");
    step(0, 1, 1, 2'd0, 6'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 survives soft reset");

    // random phase
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] r = $urandom;
      logic [3:0]  i = (r[1:0] == 0) ? 4'd2 : 4'($urandom % 16);
      logic        w = r[2];
      logic [1:0]  sz = (r[5:3] == 0) ? 2'($urandom % 3) : 2'd2;
      logic        win = (r[8:6] == 0);
      logic        ev = (($urandom % 5) == 0);
      if (win) sz = (r[9]) ? 2'd0 : sz;
      step(w, r[10], win, sz, {i, r[12:11]}, $urandom, ev, r[13], r[14], r[15] & r[16],
           4'($urandom), 8'($urandom), $urandom, $urandom, win ? "R9 rand" : "R1 rand");
      if (($urandom % 200) == 0) soft_reset();
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule